// File: doc/BRIEF.md
# Extended Match-Channel Timer

This block holds eight match channels, indexed 0 to 7 in this project. Each channel has a 32-bit counter, a 32-bit match value and a control word. A channel counts the one-cycle strobes of the tick source that its control word selects. It can also leave its own counter idle and compare against the counter of its group leader. When the counter that a channel watches steps onto that channel's match value, the channel raises its status bit. It can then clear its own counter, and it either stays armed for later matches or disarms until its match value is written again.

Channels share counters in three groups: channels 0 to 3 follow channel 0, channels 4 and 5 follow channel 4, and channels 6 and 7 follow channel 6. Channels 5 and 7 can also capture their leader's counter into a shared snapshot register whenever their own counter is read. A single interrupt line summarises all eight status bits.

Software reaches every register through a word-addressed read/write port: single-cycle write strobes and a combinational read. The tick strobe generators sit outside the block and arrive on `tick_i`, synchronous to `clk`.

Top module: `xmt_match_timer`

## Requirements
- R1: After reset every counter, match value, control word, status bit and the snapshot read as zero, and `irq_o` is low.
- R2: Byte addresses are word aligned. Channel i has its counter at 0x40+4i, its match value at 0x80+4i and its control word at 0xC0+4i. Status is at 0x14 and the snapshot at 0x20. Any other address, including a misaligned one, reads as zero and a write to it changes nothing.
- R3: Control bits [2:0] pick the tick source. Code 0 and codes 6 to 7 mean stopped, and codes 1 to 5 select `tick_i[code-1]`. A running counter advances by one on each strobe of its selected source and holds otherwise. A stopped counter still reads back and can still be written.
- R4: Channels 0, 4 and 6 always count their own source. Any other channel with control bit 7 clear compares against its leader's counter, and its own counter does not advance. With bit 7 set it counts and compares its own counter.
- R5: A match fires in the cycle where the watched counter advances onto the channel's match value while the channel is armed. Status bit 4+i is set at the next clock edge. Writing the match value arms the channel.
- R6: With control bit 3 set, a match loads the channel's own counter with zero instead of the incremented value.
- R7: With control bit 6 set the channel stays armed after a match. With it clear the channel disarms and fires again only after its match value is rewritten.
- R8: Control words of channels 0 to 3 keep bits [7:0]; those of channels 4 to 7 keep bits [9:0]. On channels 4 to 7, bit 8 set halts the counter whatever source code is chosen.
- R9: A read of the counter of channel 5 (or 7) whose control bit 9 is set copies the counter of channel 4 (or 6) into the snapshot register. Other reads leave the snapshot unchanged.
- R10: A write to status clears each bit i where data bit 4+i is 1. A match in the same cycle wins over the clear for its bit.
- R11: `irq_o` goes high one edge after any match. It falls only on a status write that clears at least one set bit and leaves no bit set.
- R12: A counter write in the same cycle as a strobe loads the written value. That counter does not advance and produces no match in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers and strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 5 | One-cycle strobes of the five tick sources |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives snapshot capture) |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq_o | output | 1 | Combined match interrupt |

## Verification
Directed sequences cover the following cases:
- Source selection, using strobes on sources a channel did not select, so that a wrong tick mux shows up as a stray increment.
- Leader-following against own-clock counting, where a follower's idle counter separates the two paths.
- One-shot against periodic matching, using a counter written back onto the match value.
- Overlapping status sets and clears, including a clear that misses and a clear in the same cycle as a match.
- A counter write in a strobe cycle, which separates write priority from match suppression.

A long run of random strobes, register writes and reads then drives all eight channels at once. A behavioural model tracks the whole register file and is compared on every read and every cycle of `irq_o`, which exposes ordering mistakes between groups and within a single cycle.

// File: rtl/xmt_pkg.sv
package xmt_pkg;

  localparam int unsigned XMT_NSRC   = 5;
  localparam int unsigned XMT_CTLW   = 10;
  localparam int unsigned XMT_STBASE = 4;

  localparam int unsigned BIT_RSTM   = 3;
  localparam int unsigned BIT_PERIOD = 6;
  localparam int unsigned BIT_OWN    = 7;
  localparam int unsigned BIT_HALT   = 8;
  localparam int unsigned BIT_SNAP   = 9;

  // Channel whose counter a group member follows.
  function automatic int unsigned group_leader(input int unsigned ch);
    if (ch < 4) return 0;
    if (ch < 6) return 4;
    return 6;
  endfunction

  // Channels able to capture their leader on a counter read.
  function automatic logic has_snap(input int unsigned ch);
    return (ch == 5) || (ch == 7);
  endfunction

  // Writable control bits per channel.
  function automatic logic [XMT_CTLW-1:0] ctl_keep(input int unsigned ch);
    return (ch < 4) ? 10'h0FF : 10'h3FF;
  endfunction

  // Strobe of the selected source; codes 0 and above XMT_NSRC are stopped.
  function automatic logic src_strobe(input logic [2:0] code,
                                      input logic [XMT_NSRC-1:0] ticks);
    logic s;
    s = 1'b0;
    if (code >= 3'd1 && code <= 3'(XMT_NSRC)) s = ticks[code - 3'd1];
    return s;
  endfunction

endpackage

// File: rtl/xmt_channel.sv
module xmt_channel
  import xmt_pkg::*;
#(
  parameter int unsigned IDX = 0,
  parameter int unsigned CW  = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cnt_we,
  input  logic                mat_we,
  input  logic                ctl_we,
  input  logic [CW-1:0]       wdata,
  input  logic [XMT_NSRC-1:0] tick_i,
  input  logic [CW-1:0]       lead_cnt_i,
  input  logic                lead_adv_i,
  output logic [CW-1:0]       cnt_o,
  output logic [CW-1:0]       mat_o,
  output logic [XMT_CTLW-1:0] ctl_o,
  output logic                adv_o,
  output logic                evt_o
);

  localparam bit                  IS_LEAD = (group_leader(IDX) == IDX);
  localparam logic [XMT_CTLW-1:0] KEEP    = ctl_keep(IDX);

  function automatic logic [CW-1:0] plus_one(input logic [CW-1:0] v);
    return v + {{(CW-1){1'b0}}, 1'b1};
  endfunction

  logic [CW-1:0]       cnt_q, mat_q;
  logic [XMT_CTLW-1:0] ctl_q;
  logic                armed_q;

  logic          uses_own, src_hit, cmp_adv;
  logic [CW-1:0] cmp_cnt;

  assign uses_own = IS_LEAD | ctl_q[BIT_OWN];
  assign src_hit  = src_strobe(ctl_q[2:0], tick_i);
  assign adv_o    = uses_own & ~ctl_q[BIT_HALT] & src_hit & ~cnt_we;
  assign cmp_cnt  = uses_own ? cnt_q : lead_cnt_i;
  assign cmp_adv  = uses_own ? adv_o : lead_adv_i;
  assign evt_o    = armed_q & cmp_adv & (plus_one(cmp_cnt) == mat_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      mat_q   <= '0;
      ctl_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (cnt_we)                         cnt_q <= wdata;
      else if (evt_o && ctl_q[BIT_RSTM])  cnt_q <= '0;
      else if (adv_o)                     cnt_q <= plus_one(cnt_q);

      if (mat_we) begin
        mat_q   <= wdata;
        armed_q <= 1'b1;
      end else if (evt_o && !ctl_q[BIT_PERIOD]) begin
        armed_q <= 1'b0;
      end

      if (ctl_we) ctl_q <= wdata[XMT_CTLW-1:0] & KEEP;
    end
  end

  assign cnt_o = cnt_q;
  assign mat_o = mat_q;
  assign ctl_o = ctl_q;

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_we && !adv_o && !evt_o) |=> $stable(cnt_q));

  // R6
  clear_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_o && ctl_q[BIT_RSTM] && !cnt_we) |=> (cnt_q == '0));

  // R7
  single_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_o && !ctl_q[BIT_PERIOD] && !mat_we) |=> !evt_o);

  // R12
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (cnt_q == $past(wdata)));

endmodule

// File: rtl/xmt_irq.sv
module xmt_irq #(
  parameter int unsigned NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] evt_i,
  input  logic           clr_we,
  input  logic [NCH-1:0] clr_mask,
  output logic [NCH-1:0] status_o,
  output logic           irq_o
);

  logic [NCH-1:0] status_q, status_d, clr_eff;
  logic           irq_q, clr_touch;

  assign clr_eff   = clr_we ? clr_mask : '0;
  assign status_d  = (status_q & ~clr_eff) | evt_i;
  assign clr_touch = |(clr_eff & status_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      if (|evt_i)                            irq_q <= 1'b1;
      else if (clr_touch && status_d == '0)  irq_q <= 1'b0;
    end
  end

  assign status_o = status_q;
  assign irq_o    = irq_q;

  // R11
  irq_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (|status_q));

  // R5
  status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((status_q & $past(evt_i)) == $past(evt_i)));

  // R10
  clear_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && ((clr_mask & status_q) == '0) && evt_i == '0) |=> $stable(status_q));

endmodule

// File: rtl/xmt_regif.sv
module xmt_regif
  import xmt_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned CW  = 32,
  parameter int unsigned AW  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic                          rd_en,
  input  logic [AW-1:0]                 addr,
  input  logic [CW-1:0]                 wdata,
  input  logic [NCH-1:0][CW-1:0]        cnt_i,
  input  logic [NCH-1:0][CW-1:0]        mat_i,
  input  logic [NCH-1:0][XMT_CTLW-1:0]  ctl_i,
  input  logic [NCH-1:0]                status_i,
  output logic [NCH-1:0]                cnt_we,
  output logic [NCH-1:0]                mat_we,
  output logic [NCH-1:0]                ctl_we,
  output logic                          clr_we,
  output logic [NCH-1:0]                clr_mask,
  output logic [CW-1:0]                 rdata
);

  localparam int unsigned IW  = $clog2(NCH);
  localparam int unsigned GSH = IW + 2;
  localparam int unsigned GW  = AW - GSH;
  localparam logic [GW-1:0] G_CNT  = GW'('h40 >> GSH);
  localparam logic [GW-1:0] G_MAT  = GW'('h80 >> GSH);
  localparam logic [GW-1:0] G_CTL  = GW'('hC0 >> GSH);
  localparam logic [AW-1:0] A_STAT = AW'('h14);
  localparam logic [AW-1:0] A_SNAP = AW'('h20);

  logic          aligned, in_cnt, in_mat, in_ctl, hit_stat, hit_snap;
  logic [IW-1:0] sel;
  logic [CW-1:0] snap_q, snap_val;
  logic          snap_load;

  assign aligned  = (addr[1:0] == 2'b00);
  assign sel      = addr[GSH-1:2];
  assign in_cnt   = aligned && (addr[AW-1:GSH] == G_CNT);
  assign in_mat   = aligned && (addr[AW-1:GSH] == G_MAT);
  assign in_ctl   = aligned && (addr[AW-1:GSH] == G_CTL);
  assign hit_stat = (addr == A_STAT);
  assign hit_snap = (addr == A_SNAP);

  for (genvar g = 0; g < NCH; g++) begin : g_dec
    assign cnt_we[g] = wr_en & in_cnt & (sel == IW'(g));
    assign mat_we[g] = wr_en & in_mat & (sel == IW'(g));
    assign ctl_we[g] = wr_en & in_ctl & (sel == IW'(g));
  end

  assign clr_we   = wr_en & hit_stat;
  assign clr_mask = wdata[XMT_STBASE +: NCH];

  always_comb begin
    snap_load = 1'b0;
    snap_val  = snap_q;
    for (int unsigned i = 0; i < NCH; i++) begin
      if (has_snap(i) && rd_en && in_cnt && sel == IW'(i) && ctl_i[i][BIT_SNAP]) begin
        snap_load = 1'b1;
        snap_val  = cnt_i[group_leader(i)];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         snap_q <= '0;
    else if (snap_load) snap_q <= snap_val;
  end

  always_comb begin
    rdata = '0;
    if (in_cnt)        rdata = cnt_i[sel];
    else if (in_mat)   rdata = mat_i[sel];
    else if (in_ctl)   rdata = CW'(ctl_i[sel]);
    else if (hit_stat) rdata = CW'(status_i) << XMT_STBASE;
    else if (hit_snap) rdata = snap_q;
  end

endmodule

// File: rtl/xmt_match_timer.sv
module xmt_match_timer
  import xmt_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned CW  = 32,
  parameter int unsigned AW  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [XMT_NSRC-1:0] tick_i,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [AW-1:0]       addr,
  input  logic [CW-1:0]       wdata,
  output logic [CW-1:0]       rdata,
  output logic                irq_o
);

  logic [NCH-1:0][CW-1:0]       cnt_bus, mat_bus;
  logic [NCH-1:0][XMT_CTLW-1:0] ctl_bus;
  logic [NCH-1:0]               adv_bus, evt_bus, status;
  logic [NCH-1:0]               cnt_we, mat_we, ctl_we, clr_mask;
  logic                         clr_we;

  xmt_regif #(.NCH(NCH), .CW(CW), .AW(AW)) regif_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .cnt_i    (cnt_bus),
    .mat_i    (mat_bus),
    .ctl_i    (ctl_bus),
    .status_i (status),
    .cnt_we   (cnt_we),
    .mat_we   (mat_we),
    .ctl_we   (ctl_we),
    .clr_we   (clr_we),
    .clr_mask (clr_mask),
    .rdata    (rdata)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int unsigned LEAD = group_leader(g);
    xmt_channel #(.IDX(g), .CW(CW)) ch_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cnt_we     (cnt_we[g]),
      .mat_we     (mat_we[g]),
      .ctl_we     (ctl_we[g]),
      .wdata      (wdata),
      .tick_i     (tick_i),
      .lead_cnt_i (cnt_bus[LEAD]),
      .lead_adv_i (adv_bus[LEAD]),
      .cnt_o      (cnt_bus[g]),
      .mat_o      (mat_bus[g]),
      .ctl_o      (ctl_bus[g]),
      .adv_o      (adv_bus[g]),
      .evt_o      (evt_bus[g])
    );
  end

  xmt_irq #(.NCH(NCH)) irq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (evt_bus),
    .clr_we   (clr_we),
    .clr_mask (clr_mask),
    .status_o (status),
    .irq_o    (irq_o)
  );

endmodule

// File: tb/xmt_match_timer_tb_top.sv
module xmt_match_timer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  tick = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0, cmp_on = 0;

  always #4 clk = ~clk;

  xmt_match_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq)
  );

  // ---------------- behavioural reference ----------------
  logic [31:0] m_cnt[8], m_mat[8], m_ctl[8];
  bit          m_arm[8];
  logic [7:0]  m_st;
  logic [31:0] m_snap;
  bit          m_irq;
  bit          b_adv[8], b_hit[8];

  function automatic int lead(int k);
    if (k < 4) return 0;
    if (k < 6) return 4;
    return 6;
  endfunction

  function automatic logic [7:0] a_cnt(int k); return 8'h40 + 8'(4*k); endfunction
  function automatic logic [7:0] a_mat(int k); return 8'h80 + 8'(4*k); endfunction
  function automatic logic [7:0] a_ctl(int k); return 8'hC0 + 8'(4*k); endfunction

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    for (int k = 0; k < 8; k++) begin
      if (a == a_cnt(k)) return m_cnt[k];
      if (a == a_mat(k)) return m_mat[k];
      if (a == a_ctl(k)) return m_ctl[k];
    end
    if (a == 8'h14) return {20'd0, m_st, 4'd0};
    if (a == 8'h20) return m_snap;
    return 32'd0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 8; k++) begin
        m_cnt[k] = 0; m_mat[k] = 0; m_ctl[k] = 0; m_arm[k] = 0;
      end
      m_st = 0; m_snap = 0; m_irq = 0;
    end else begin
      logic [7:0] clr, hv, nst;
      for (int k = 0; k < 8; k++) begin
        bit own, tk;
        logic [2:0] sel;
        own = m_ctl[k][7] || (lead(k) == k);
        sel = m_ctl[k][2:0];
        tk  = (sel >= 3'd1 && sel <= 3'd5) ? tick[sel - 3'd1] : 1'b0;
        b_adv[k] = own && !m_ctl[k][8] && tk && !(wr_en && addr == a_cnt(k));
      end
      for (int k = 0; k < 8; k++) begin
        int src;
        src = (m_ctl[k][7] || lead(k) == k) ? k : lead(k);
        b_hit[k] = m_arm[k] && b_adv[src] && (m_cnt[src] + 32'd1 == m_mat[k]);
      end
      if (rd_en && addr == 8'h54 && m_ctl[5][9]) m_snap = m_cnt[4];
      if (rd_en && addr == 8'h5C && m_ctl[7][9]) m_snap = m_cnt[6];
      clr = (wr_en && addr == 8'h14) ? wdata[11:4] : 8'd0;
      for (int k = 0; k < 8; k++) hv[k] = b_hit[k];
      nst = (m_st & ~clr) | hv;
      if (hv != 0) m_irq = 1;
      else if ((clr & m_st) != 0 && nst == 0) m_irq = 0;
      m_st = nst;
      for (int k = 0; k < 8; k++) begin
        if (wr_en && addr == a_cnt(k))     m_cnt[k] = wdata;
        else if (b_hit[k] && m_ctl[k][3])  m_cnt[k] = 0;
        else if (b_adv[k])                 m_cnt[k] = m_cnt[k] + 1;
        if (wr_en && addr == a_mat(k)) begin m_mat[k] = wdata; m_arm[k] = 1; end
        else if (b_hit[k] && !m_ctl[k][6]) m_arm[k] = 0;
        if (wr_en && addr == a_ctl(k)) m_ctl[k] = wdata & ((k < 4) ? 32'h0FF : 32'h3FF);
      end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk({31'd0, irq}, {31'd0, m_irq}, "R11 model irq");
      if (rd_en) chk(rdata, exp_rd(addr), "R2 model read");
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic nxt();
    @(posedge clk); #1;
    wr_en = 0; rd_en = 0; tick = '0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    addr = a; wdata = d; wr_en = 1; rd_en = 0; tick = '0; nxt();
  endtask

  task automatic wr_tick(logic [7:0] a, logic [31:0] d, logic [4:0] t);
    addr = a; wdata = d; wr_en = 1; rd_en = 0; tick = t; nxt();
  endtask

  task automatic pulse(logic [4:0] t);
    tick = t; nxt();
  endtask

  task automatic rd_chk(logic [7:0] a, logic [31:0] exp, string tag);
    addr = a; rd_en = 1; wr_en = 0; tick = '0;
    #2 chk(rdata, exp, tag);
    nxt();
  endtask

  task automatic irq_chk(logic exp, string tag);
    #1 chk({31'd0, irq}, {31'd0, exp}, tag);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // ---------------- tests ----------------
  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1; cmp_on = 1;

    // R1 reset state
    rd_chk(8'h40, 0, "R1 counter");
    rd_chk(8'h9C, 0, "R1 match");
    rd_chk(8'hDC, 0, "R1 control");
    rd_chk(8'h14, 0, "R1 status");
    rd_chk(8'h20, 0, "R1 snapshot");
    irq_chk(0, "R1 irq");

    // R2 decode
    wr(8'h9C, 32'h12345678);
    rd_chk(8'h9C, 32'h12345678, "R2 match ch7");
    wr(8'h5C, 32'h0000CAFE);
    rd_chk(8'h5C, 32'h0000CAFE, "R2 counter ch7 (stopped, R3)");
    rd_chk(8'h24, 0, "R2 unmapped");
    rd_chk(8'h5E, 0, "R2 misaligned");
    wr(8'h5C, 0);

    // R3 source selection
    wr(8'hC0, 1);
    pulse(5'b00010);
    rd_chk(8'h40, 0, "R3 unselected source");
    pulse(5'b00001); pulse(5'b00001);
    rd_chk(8'h40, 2, "R3 selected source");
    wr(8'hC0, 6);
    pulse(5'b11111);
    rd_chk(8'h40, 2, "R3 code 6 stopped");
    wr(8'hC0, 5);
    pulse(5'b10000);
    rd_chk(8'h40, 3, "R3 code 5 external");
    wr(8'hC0, 0);
    pulse(5'b11111);
    rd_chk(8'h40, 3, "R3 code 0 stopped");

    // R5 R6 R7 match, clear-on-match, periodic
    wr(8'h40, 0); wr(8'h80, 3); wr(8'hC0, 32'h49);
    pulse(1); pulse(1);
    rd_chk(8'h14, 0, "R5 no match yet");
    pulse(1);
    irq_chk(1, "R11 irq rises");
    rd_chk(8'h14, 32'h10, "R5 status bit4");
    rd_chk(8'h40, 0, "R6 counter cleared");
    wr(8'h14, 32'h10);
    irq_chk(0, "R11 irq falls");
    pulse(1); pulse(1); pulse(1);
    rd_chk(8'h14, 32'h10, "R7 periodic rematch");
    wr(8'h14, 32'h10);
    wr(8'hC0, 1);
    pulse(1); pulse(1); pulse(1);
    rd_chk(8'h14, 32'h10, "R5 one-shot first match");
    rd_chk(8'h40, 3, "R6 no clear when bit3 low");
    wr(8'h14, 32'h10);
    wr(8'h40, 2); pulse(1);
    rd_chk(8'h14, 0, "R7 disarmed");
    wr(8'h80, 4); pulse(1);
    rd_chk(8'h14, 32'h10, "R7 rearmed by match write");
    wr(8'h14, 32'h10);

    // R4 grouping
    wr(8'hC4, 0); wr(8'h84, 6); wr(8'h44, 32'h77);
    pulse(1); pulse(1);
    rd_chk(8'h14, 32'h20, "R4 follower matches leader counter");
    rd_chk(8'h44, 32'h77, "R4 follower counter idle");
    wr(8'h14, 32'h20);
    wr(8'hC4, 32'h82); wr(8'h44, 0);
    pulse(5'b00001);
    rd_chk(8'h44, 0, "R4 own clock ignores leader source");
    pulse(5'b00010);
    rd_chk(8'h44, 1, "R4 own clock counts");

    // R8 control widths and halt
    wr(8'hC8, 32'hFFFFFFFF);
    rd_chk(8'hC8, 32'hFF, "R8 narrow control");
    wr(8'hD0, 32'hFFFFFFFF);
    rd_chk(8'hD0, 32'h3FF, "R8 wide control");
    wr(8'hC8, 0);
    wr(8'h50, 0); wr(8'hD0, 32'h181);
    pulse(1);
    rd_chk(8'h50, 0, "R8 halt bit");
    wr(8'hD0, 32'h081);
    pulse(1);
    rd_chk(8'h50, 1, "R8 running after halt cleared");

    // R9 snapshot
    pulse(1); pulse(1);
    wr(8'hD4, 32'h200);
    rd_chk(8'h54, 0, "R9 partner counter");
    rd_chk(8'h20, 3, "R9 snapshot of leader");
    wr(8'h58, 0); wr(8'hD8, 32'h081);
    pulse(1);
    rd_chk(8'h5C, 0, "R9 read without enable");
    rd_chk(8'h20, 3, "R9 snapshot unchanged");
    wr(8'hDC, 32'h200);
    rd_chk(8'h5C, 0, "R9 second pair read");
    rd_chk(8'h20, 1, "R9 second pair snapshot");

    // R10 R11 status and interrupt
    wr(8'h40, 0); wr(8'h58, 0); wr(8'h80, 2); wr(8'h98, 2);
    pulse(1); pulse(1);
    rd_chk(8'h14, 32'h410, "R10 two status bits");
    wr(8'h14, 32'h800);
    rd_chk(8'h14, 32'h410, "R10 clear that misses");
    irq_chk(1, "R11 irq kept on missed clear");
    wr(8'h14, 32'h10);
    irq_chk(1, "R11 irq kept on partial clear");
    wr(8'h14, 32'h400);
    irq_chk(0, "R11 irq falls when empty");
    wr(8'h40, 0); wr(8'h80, 2); pulse(1);
    wr_tick(8'h14, 32'h10, 5'b00001);
    rd_chk(8'h14, 32'h10, "R10 set wins over clear");
    wr(8'h14, 32'h10);

    // R12 counter write against strobe
    wr(8'h40, 5); wr(8'h80, 6);
    wr_tick(8'h40, 9, 5'b00001);
    rd_chk(8'h40, 9, "R12 write wins");
    rd_chk(8'h14, 0, "R12 match suppressed");
    wr(8'h40, 5); pulse(1);
    rd_chk(8'h14, 32'h10, "R12 match after write cycle");
    wr(8'h14, 32'h10);

    // random mix checked against the model
    for (int c = 0; c < 4000; c++) begin
      int r, grp, idx;
      for (int b = 0; b < 5; b++) tick[b] = ($urandom_range(0, 3) == 0);
      r = $urandom_range(0, 9);
      grp = $urandom_range(0, 4);
      idx = $urandom_range(0, 7);
      case (grp)
        0: begin addr = a_cnt(idx); wdata = $urandom_range(0, 15); end
        1: begin addr = a_mat(idx); wdata = $urandom_range(0, 15); end
        2: begin addr = a_ctl(idx); wdata = $urandom & 32'h3FF; end
        3: begin addr = 8'h14; wdata = $urandom; end
        default: begin addr = 8'h20; wdata = $urandom; end
      endcase
      wr_en = (r < 2);
      rd_en = (r >= 2 && r < 5);
      @(posedge clk); #1;
    end
    wr_en = 0; rd_en = 0; tick = '0;
    @(posedge clk); #1;

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule